// File: doc/BRIEF.md
# Wormhole Flit Link with Request/Acknowledge Pacing

This block carries one wormhole-routed channel between two neighbouring routers. The sending side takes flits from a local packet queue, one at a time, and puts each on the link. It holds the flit and raises its request until the far side takes it in. The receiving side stores arriving flits in a four-entry buffer and presents them in order to the router core through a valid/ready pair.

A single level-coded line paces the link. The receiver keeps the line low while it has room for a flit. The sender drives the line high while a flit is waiting on the data lines. Inside the block this line is modelled as two directional signals, request and receiver-ready, and a flit crosses on any clock edge where both are 1.

Packets are framed by a two-bit kind carried with every flit. The sender only lets a well-formed packet onto the link, so flits of two packets never mix. Whole packets may still follow one another back to back.

Top module: `wh_link`

## Requirements
- R1: After reset the line level `linkRa` is 0, `coreValid` is 0 and `srcReady` is 1.
- R2: `linkRa` is 1 while the sender holds a flit. When the sender holds no flit, `linkRa` is 1 only if the receiver buffer is full, and 0 otherwise.
- R3: A held flit crosses on an edge where the request and receiver-ready are both 1. While it waits, `linkData` and `linkType` stay unchanged and `srcReady` is 0.
- R4: The receiver buffer holds up to four flits and stops accepting flits when full. No flit is lost, duplicated or overwritten.
- R5: Flits reach the core in the order they were accepted, with data and kind unchanged. With an empty buffer and an idle link, a flit accepted from the source at edge k is valid at the core after edge k+1. `coreData` holds while `coreValid` is 1 and `coreReady` is 0.
- R6: The flit kind encoding is 2'b00 header, 2'b01 body, 2'b10 tail, 2'b11 single-flit packet (header and tail at once).
- R7: When no packet is open, the sender accepts only a header or a single-flit packet. When a packet is open, it accepts only body or tail flits. A flit that breaks this rule is taken from the source (`srcReady` handshake completes) but is never sent.
- R8: On the link, a header or single-flit packet crosses only when no packet is open, and body or tail flits cross only inside an open packet. A new packet starts only after the previous tail has crossed.
- R9: `srcReady` is 1 whenever the sender holds no flit or its flit crosses in the current cycle. With the core always ready, flits stream at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Local queue offers a flit |
| srcType | input | 2 | Kind of the offered flit |
| srcData | input | DATA_W | Payload of the offered flit |
| srcReady | output | 1 | Sender takes the offered flit this cycle |
| linkRa | output | 1 | Level of the shared request/acknowledge line |
| linkType | output | 2 | Kind of the flit on the link |
| linkData | output | DATA_W | Payload on the link |
| coreValid | output | 1 | Receiver buffer presents a flit |
| coreType | output | 2 | Kind of the presented flit |
| coreData | output | DATA_W | Payload of the presented flit |
| coreReady | input | 1 | Router core takes the presented flit |

## Verification
The bench fills the receiver buffer while the core is stalled, then checks that the line reads high with no flit waiting, and that a fifth flit stays frozen on the link instead of overwriting an entry. A design that ignored fullness would lose or reorder flits, and the scoreboard would catch it. The bench also offers out-of-place body, tail and header flits. A design without the framing guard would forward them and interleave packets. Streaming and stall-toggling runs catch a sender that needs a dead cycle between flits or that moves its data while its request waits.

// File: rtl/wh_link_pkg.sv
package wh_link_pkg;

  typedef enum logic [1:0] {
    KIND_HEAD = 2'b00,
    KIND_BODY = 2'b01,
    KIND_TAIL = 2'b10,
    KIND_SOLO = 2'b11
  } flit_kind_t;

  typedef struct packed {
    logic loadTx;   // capture source flit into the sender register
    logic push;     // flit crosses the link into the receive buffer
    logic pop;      // core takes the head of the receive buffer
  } link_strb_t;

endpackage

// File: rtl/wh_link_ctrl.sv
module wh_link_ctrl
  import wh_link_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcValid,
  input  logic [1:0] srcType,
  input  logic [1:0] linkType,
  input  logic       coreReady,
  output logic       srcReady,
  output logic       linkReq,
  output logic       rxRdy,
  output logic       coreValid,
  output link_strb_t strb
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             txValid;
  logic             pktOpen;
  logic [CNT_W-1:0] rxCount;
  logic             xfer;
  logic             accept;
  logic             legal;
  logic             loadTx;
  logic             pop;

  assign rxRdy     = rxCount < CNT_W'(DEPTH);
  assign xfer      = txValid & rxRdy;
  assign srcReady  = ~txValid | xfer;
  assign accept    = srcValid & srcReady;
  assign legal     = pktOpen ? (srcType == KIND_BODY || srcType == KIND_TAIL)
                             : (srcType == KIND_HEAD || srcType == KIND_SOLO);
  assign loadTx    = accept & legal;
  assign coreValid = rxCount != '0;
  assign pop       = coreValid & coreReady;
  assign linkReq   = txValid;

  always_comb begin
    strb        = '0;
    strb.loadTx = loadTx;
    strb.push   = xfer;
    strb.pop    = pop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      pktOpen <= 1'b0;
      rxCount <= '0;
    end else begin
      if (loadTx)    txValid <= 1'b1;
      else if (xfer) txValid <= 1'b0;
      if (loadTx) begin
        if (srcType == KIND_HEAD)      pktOpen <= 1'b1;
        else if (srcType == KIND_TAIL) pktOpen <= 1'b0;
      end
      case ({xfer, pop})
        2'b10:   rxCount <= rxCount + 1'b1;
        2'b01:   rxCount <= rxCount - 1'b1;
        default: rxCount <= rxCount;
      endcase
    end
  end

  // Receiver-side view of packet framing, tracked from what crosses the link
  logic rxOpen;
  always_ff @(posedge clk) begin
    if (!rstN) rxOpen <= 1'b0;
    else if (xfer) begin
      if (linkType == KIND_HEAD)      rxOpen <= 1'b1;
      else if (linkType == KIND_TAIL) rxOpen <= 1'b0;
    end
  end

  p_framing_r8: assert property (@(posedge clk) disable iff (!rstN)
    xfer |-> (rxOpen ? (linkType == KIND_BODY || linkType == KIND_TAIL)
                     : (linkType == KIND_HEAD || linkType == KIND_SOLO)));

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (linkReq && !rxRdy) |=> linkReq);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

endmodule

// File: rtl/wh_link_dp.sv
module wh_link_dp
  import wh_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  link_strb_t        strb,
  input  logic              txHeld,
  input  logic              rxRdy,
  input  logic [1:0]        srcType,
  input  logic [DATA_W-1:0] srcData,
  output logic [1:0]        linkType,
  output logic [DATA_W-1:0] linkData,
  output logic [1:0]        coreType,
  output logic [DATA_W-1:0] coreData
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = DATA_W + 2;

  logic [1:0]        txType;
  logic [DATA_W-1:0] txData;
  logic [ENT_W-1:0]  mem [DEPTH];
  logic [IDX_W-1:0]  wrPtr;
  logic [IDX_W-1:0]  rdPtr;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txType <= KIND_HEAD;
      txData <= '0;
    end else if (strb.loadTx) begin
      txType <= srcType;
      txData <= srcData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= {txType, txData};
  end

  assign linkType = txType;
  assign linkData = txData;
  assign {coreType, coreData} = mem[rdPtr];

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txHeld && !rxRdy) |=> ($stable(txData) && $stable(txType)));

endmodule

// File: rtl/wh_link.sv
module wh_link
  import wh_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcValid,
  input  logic [1:0]        srcType,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  output logic              linkRa,
  output logic [1:0]        linkType,
  output logic [DATA_W-1:0] linkData,
  output logic              coreValid,
  output logic [1:0]        coreType,
  output logic [DATA_W-1:0] coreData,
  input  logic              coreReady
);
  link_strb_t strb;
  logic       linkReq;
  logic       rxRdy;

  wh_link_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcType(srcType),
    .linkType(linkType), .coreReady(coreReady), .srcReady(srcReady),
    .linkReq(linkReq), .rxRdy(rxRdy), .coreValid(coreValid), .strb(strb)
  );

  wh_link_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txHeld(linkReq), .rxRdy(rxRdy),
    .srcType(srcType), .srcData(srcData), .linkType(linkType),
    .linkData(linkData), .coreType(coreType), .coreData(coreData)
  );

  // Shared line: high while sending, otherwise low only when receiver has room
  assign linkRa = linkReq | ~rxRdy;

  p_core_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && !coreReady) |=> (coreValid && $stable(coreData) && $stable(coreType)));

endmodule

// File: tb/wh_link_tb.sv
module wh_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          srcValid = 1'b0;
  logic [1:0]    srcType = 2'b00;
  logic [DW-1:0] srcData = '0;
  logic          srcReady;
  logic          linkRa;
  logic [1:0]    linkType;
  logic [DW-1:0] linkData;
  logic          coreValid;
  logic [1:0]    coreType;
  logic [DW-1:0] coreData;
  logic          coreReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastAccept = 0;
  bit doneFlag = 1'b0;
  logic [DW+1:0] expQ[$];
  bit monOpen = 1'b0;

  wh_link #(.DATA_W(DW), .DEPTH(4)) u_dut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcType(srcType),
    .srcData(srcData), .srcReady(srcReady), .linkRa(linkRa),
    .linkType(linkType), .linkData(linkData), .coreValid(coreValid),
    .coreType(coreType), .coreData(coreData), .coreReady(coreReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: offers one flit, waits for acceptance, records expectation if legal
  task automatic sendFlit(input logic [1:0] kind, input logic [DW-1:0] d, input bit legal);
    bit rdy;
    srcValid = 1'b1; srcType = kind; srcData = d;
    forever begin
      @(negedge clk) rdy = srcReady;
      @(posedge clk);
      #1;
      if (rdy) break;
    end
    lastAccept = cyc;
    if (legal) expQ.push_back({kind, d});
    srcValid = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Monitor / scoreboard: R4, R5, R6 order and content; R8 framing at the core
  always @(negedge clk) begin
    if (rstN && coreValid && coreReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected flit at core", {coreType, coreData}, 0);
      end else begin
        logic [DW+1:0] e;
        e = expQ.pop_front();
        check({coreType, coreData} == e, "R5/R6 core flit", {coreType, coreData}, e);
      end
      check(monOpen ? (coreType == 2'b01 || coreType == 2'b10)
                    : (coreType == 2'b00 || coreType == 2'b11),
            "R8 framing at core", coreType, monOpen);
      if (coreType == 2'b00) monOpen = 1'b1;
      else if (coreType == 2'b10) monOpen = 1'b0;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    check(linkRa == 1'b0, "R1 linkRa reset", linkRa, 0);
    check(coreValid == 1'b0, "R1 coreValid reset", coreValid, 0);
    check(srcReady == 1'b1, "R1 srcReady reset", srcReady, 1);

    // R5 latency and R6 single-flit encoding
    @(posedge clk); #1;
    coreReady = 1'b1;
    sendFlit(2'b11, 16'h5A01, 1'b1);
    @(negedge clk);
    check(linkRa == 1'b1, "R2 line high while sending", linkRa, 1);
    check(coreValid == 1'b0, "R5 not yet at core", coreValid, 0);
    @(negedge clk);
    check(coreValid == 1'b1 && coreType == 2'b11, "R5 latency / R6 solo kind",
          {coreValid, coreType}, 3'b111);
    waitCycles(2);
    @(negedge clk);
    check(linkRa == 1'b0, "R2 line low when idle with room", linkRa, 0);

    // R4 / R2 / R3: fill buffer with core stalled
    @(posedge clk); #1;
    coreReady = 1'b0;
    sendFlit(2'b00, 16'hA000, 1'b1);
    sendFlit(2'b01, 16'hA001, 1'b1);
    sendFlit(2'b01, 16'hA002, 1'b1);
    sendFlit(2'b01, 16'hA003, 1'b1);
    waitCycles(3);
    @(negedge clk);
    check(linkRa == 1'b1 && srcReady == 1'b1, "R2 line high when full and idle",
          {linkRa, srcReady}, 2'b11);
    check(coreValid && coreData == 16'hA000, "R4 head entry kept", coreData, 16'hA000);
    fork
      begin
        sendFlit(2'b10, 16'hA004, 1'b1);
        sendFlit(2'b11, 16'hB000, 1'b1);
      end
      begin
        waitCycles(2);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          check(linkData == 16'hA004 && linkType == 2'b10, "R3 held flit stable",
                {linkType, linkData}, {2'b10, 16'hA004});
          check(srcReady == 1'b0 && linkRa == 1'b1, "R3 sender stalled",
                {srcReady, linkRa}, 2'b01);
        end
        @(posedge clk); #1;
        coreReady = 1'b1;
      end
    join
    waitCycles(8);
    check(expQ.size() == 0, "R4 all stalled flits delivered", expQ.size(), 0);

    // R7: out-of-place flits dropped
    sendFlit(2'b01, 16'hDEAD, 1'b0);
    sendFlit(2'b10, 16'hDEAF, 1'b0);
    waitCycles(3);
    @(negedge clk);
    check(coreValid == 1'b0, "R7 stray body/tail not sent", coreValid, 0);
    check(srcReady == 1'b1 && linkRa == 1'b0, "R7 stray flits consumed",
          {srcReady, linkRa}, 2'b10);
    @(posedge clk); #1;
    sendFlit(2'b00, 16'hC000, 1'b1);
    sendFlit(2'b00, 16'hBAD0, 1'b0);
    sendFlit(2'b11, 16'hBAD1, 1'b0);
    sendFlit(2'b01, 16'hC001, 1'b1);
    sendFlit(2'b10, 16'hC002, 1'b1);
    waitCycles(6);
    check(expQ.size() == 0, "R7 legal flits of packet delivered", expQ.size(), 0);

    // R9: back-to-back streaming at one flit per cycle
    begin
      int startCyc;
      sendFlit(2'b00, 16'hE000, 1'b1);
      startCyc = lastAccept;
      for (int i = 1; i < 7; i++) sendFlit(2'b01, DW'(16'hE000 + i), 1'b1);
      sendFlit(2'b10, 16'hE007, 1'b1);
      check(lastAccept - startCyc == 7, "R9 one flit per cycle", lastAccept - startCyc, 7);
    end
    waitCycles(6);

    // Mixed stream with a core that stalls in a pattern (R4, R5, R8)
    fork
      begin
        for (int p = 0; p < 6; p++) begin
          if (p % 3 == 2) sendFlit(2'b11, DW'(16'h7000 + p), 1'b1);
          else begin
            sendFlit(2'b00, DW'(16'h6000 + p * 16), 1'b1);
            for (int b = 1; b <= p + 1; b++) sendFlit(2'b01, DW'(16'h6000 + p * 16 + b), 1'b1);
            sendFlit(2'b10, DW'(16'h600F + p * 16), 1'b1);
          end
        end
      end
      begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        for (int i = 0; i < 120; i++) begin
          @(posedge clk); #1;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          coreReady = lfsr[0] | lfsr[2];
        end
        coreReady = 1'b1;
      end
    join
    waitCycles(10);
    check(expQ.size() == 0, "R4 mixed stream fully delivered", expQ.size(), 0);
    check(monOpen == 1'b0, "R8 stream ends between packets", monOpen, 0);

    doneFlag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule